// File: doc/BRIEF.md
# Column-Systolic Binary Template Correlator

This block correlates a 16x16 binary template against a stream of 8-bit pixels. The image is a horizontal strip 16 rows tall. It arrives one pixel per accepted transfer, top to bottom within a column and then column after column. A chain of 16 identical column elements holds one template column each. Every element sees the same pixel. When its template bit for the current row is 1, it adds the pixel to the partial sum it is building. At each column boundary, element k takes the finished partial sum of element k-1. Element 0 takes zero. Each running sum therefore meets template column j while image column c+j is passing. The last element completes one full correlation per column once the chain has filled.

A token, given with the first pixel of a frame, restarts the row and column framing. As the frame advances, the token walks down the chain one element per column. Element k fetches its new template column through a small read port when the frame's first partial sum reaches it. Sums that were still in flight under the previous template are never delivered. The first result of a frame appears only after all 16 columns of that frame have passed through the chain.

Both streams use valid/ready. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high. An output transfer happens on an edge where `out_valid` and `out_ready` are both high. While a result waits for `out_ready`, the whole chain stalls: `in_ready` is low and the result holds. `in_ready` is high whenever no result is waiting or the waiting result is being taken in the same cycle. The template read port is plain and combinational: the data must answer the column index in the same cycle.

Top module: `corr_column_chain`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The result for image column offset c of a frame equals the sum, over template column j and row r, of T[j][r]·P[c+j][r], taken modulo 2^13. T is the template as read for the frame and P is the frame's pixel data.
- R3: Once the chain has filled, exactly one result is produced per 16 accepted pixels. A frame of N full columns yields N-15 results.
- R4: After a token, results become valid starting with the 256th accepted pixel of the frame (counting the token pixel), at the end of every later column. No sum begun before the token is ever delivered.
- R5: For k = 0..15, the pixel accepted at frame position 16·k (the token pixel is position 0) raises `tpl_rd_en` in the same cycle with `tpl_rd_col` = k. There are no other reads.
- R6: Bit r of `tpl_rd_bits` is the template bit for row r, where row 0 is the first pixel of a column. Template column j is applied to image column c+j.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_sum` stay unchanged into the next cycle.
- R8: Before the first token after reset, pixels produce no result and no template read.
- R9: A token given in the middle of a column restarts the framing: the token pixel becomes row 0 of column 0 of the new frame.
- R10: The partial sums are 13 bits wide and wrap. A full template over pixels of 255 gives (65280 mod 8192) = 7936.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be taken |
| in_pix | input | 8 | Pixel value |
| in_tok | input | 1 | Frame start / template change token, qualified by `in_valid` |
| out_valid | output | 1 | Correlation result waiting |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 13 | Correlation result |
| tpl_rd_en | output | 1 | Template column read strobe |
| tpl_rd_col | output | 4 | Template column index being read |
| tpl_rd_bits | input | 16 | Template column bits, answered in the same cycle |

## Verification
The assertions check the stream rules on every cycle: a held result stays put and input is blocked while it waits. They also check, against a counter kept inside the checker, that each template read happens only at its own column slot and on an accepted pixel. They check that a result appears right after each fill-complete column boundary and never otherwise, and that nothing moves before the first token. The bench scenarios show the arithmetic: the correlation values against a model of the sum, the row and column bit ordering, the 13-bit wrap, and the dropping of in-flight sums when a token arrives mid-column.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Per-transfer control seen by every column element.
  typedef struct packed {
    logic fire;       // a pixel is accepted this cycle
    logic row_first;  // the accepted pixel is row 0 of its column
  } step_t;

  // Index width that stays at least one bit.
  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/corr_seq.sv
module corr_seq
  import corr_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int RW = cw(ROWS),
  localparam int IW = cw(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          tok,
  output step_t         step,
  output logic [RW-1:0] row,
  output logic          ld_en,
  output logic [IW-1:0] ld_col,
  output logic          res_stb
);
  localparam int CW = cw(COLS + 1);

  logic [RW-1:0] row_q, row_e;
  logic [CW-1:0] col_q, col_e;
  logic          primed_q, primed_e, row_last, filling;

  // A token makes its own pixel row 0 of column 0.
  always_comb begin
    row_e    = tok ? '0 : row_q;
    col_e    = tok ? '0 : col_q;
    primed_e = primed_q | tok;
    row_last = (row_e == RW'(ROWS - 1));
    filling  = (col_e < CW'(COLS));
  end

  always_comb begin
    step.fire      = fire;
    step.row_first = (row_e == '0);
    row            = row_e;
    ld_en          = fire && primed_e && (row_e == '0) && filling;
    ld_col         = IW'(col_e);
    res_stb        = fire && primed_e && row_last && (col_e >= CW'(COLS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= CW'(COLS);
      primed_q <= 1'b0;
    end else if (fire) begin
      row_q    <= row_last ? '0 : row_e + 1'b1;
      col_q    <= (row_last && filling) ? col_e + 1'b1 : col_e;
      primed_q <= primed_e;
    end
  end

endmodule

// File: rtl/corr_col_pe.sv
module corr_col_pe
  import corr_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int PIX_W = 8,
  parameter int SUM_W = 13,
  parameter int RW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_t            step,
  input  logic [RW-1:0]    row,
  input  logic [PIX_W-1:0] pix,
  input  logic             ld,
  input  logic [ROWS-1:0]  ld_bits,
  input  logic [SUM_W-1:0] sum_in,
  output logic [SUM_W-1:0] part,
  output logic [SUM_W-1:0] sum_nxt
);
  logic [ROWS-1:0]  tmpl_q;
  logic [SUM_W-1:0] part_q, base, addend;
  logic             tbit;

  always_comb begin
    // A freshly fetched column applies already to its first pixel.
    tbit    = ld ? ld_bits[row] : tmpl_q[row];
    addend  = tbit ? SUM_W'(pix) : '0;
    // Row 0 starts from the neighbour's finished column sum.
    base    = step.row_first ? sum_in : part_q;
    sum_nxt = base + addend;
    part    = part_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmpl_q <= '0;
      part_q <= '0;
    end else begin
      if (ld)        tmpl_q <= ld_bits;
      if (step.fire) part_q <= sum_nxt;
    end
  end

endmodule

// File: rtl/corr_out_stage.sv
module corr_out_stage #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         hold
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= din;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_comb begin
    out_valid = vld_q;
    out_data  = dat_q;
    hold      = vld_q && !out_ready;
  end

endmodule

// File: rtl/corr_column_chain.sv
module corr_column_chain
  import corr_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int PIX_W = 8,
  parameter int SUM_W = 13,
  localparam int IW = cw(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_tok,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SUM_W-1:0] out_sum,
  output logic             tpl_rd_en,
  output logic [IW-1:0]    tpl_rd_col,
  input  logic [ROWS-1:0]  tpl_rd_bits
);
  localparam int RW = cw(ROWS);

  logic          fire, hold, ld_en, res_stb;
  logic [IW-1:0] ld_col;
  logic [RW-1:0] row;
  step_t         step;

  logic [SUM_W-1:0] chain_in [COLS];
  logic [SUM_W-1:0] part_w   [COLS];
  logic [SUM_W-1:0] nxt_w    [COLS];

  assign in_ready   = !hold;
  assign fire       = in_valid && in_ready;
  assign tpl_rd_en  = ld_en;
  assign tpl_rd_col = ld_col;

  corr_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .tok     (in_tok),
    .step    (step),
    .row     (row),
    .ld_en   (ld_en),
    .ld_col  (ld_col),
    .res_stb (res_stb)
  );

  for (genvar k = 0; k < COLS; k++) begin : g_col
    logic ld_k;
    assign ld_k = ld_en && (ld_col == IW'(k));

    if (k == 0) begin : g_head
      assign chain_in[k] = '0;
    end else begin : g_link
      assign chain_in[k] = part_w[k-1];
    end

    corr_col_pe #(.ROWS(ROWS), .PIX_W(PIX_W), .SUM_W(SUM_W), .RW(RW)) u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .row     (row),
      .pix     (in_pix),
      .ld      (ld_k),
      .ld_bits (tpl_rd_bits),
      .sum_in  (chain_in[k]),
      .part    (part_w[k]),
      .sum_nxt (nxt_w[k])
    );
  end

  corr_out_stage #(.W(SUM_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (res_stb),
    .din       (nxt_w[COLS-1]),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_sum),
    .hold      (hold)
  );

endmodule

// File: rtl/corr_column_chain_chk.sv
module corr_column_chain_chk
  import corr_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int SUM_W = 13,
  localparam int IW = cw(COLS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_tok,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SUM_W-1:0] out_sum,
  input logic             tpl_rd_en,
  input logic [IW-1:0]    tpl_rd_col
);
  localparam int RW = cw(ROWS);
  localparam int CW = cw(COLS + 1);

  // Independent frame position tracker, built from the ports only.
  logic [RW-1:0] r_q, r_e;
  logic [CW-1:0] c_q, c_e;
  logic          p_q, p_e, acc, slot, done;

  always_comb begin
    acc  = in_valid && in_ready;
    r_e  = in_tok ? '0 : r_q;
    c_e  = in_tok ? '0 : c_q;
    p_e  = p_q || in_tok;
    slot = acc && p_e && (r_e == '0) && (c_e < CW'(COLS));
    done = acc && p_e && (r_e == RW'(ROWS - 1)) && (c_e >= CW'(COLS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q <= '0;
      c_q <= CW'(COLS);
      p_q <= 1'b0;
    end else if (acc) begin
      p_q <= p_e;
      if (r_e == RW'(ROWS - 1)) begin
        r_q <= '0;
        if (c_e < CW'(COLS)) c_q <= c_e + 1'b1;
        else                 c_q <= c_e;
      end else begin
        r_q <= r_e + 1'b1;
        c_q <= c_e;
      end
    end
  end

  AST_HOLD_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum)); // R7
  AST_HOLD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7
  AST_READ_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    tpl_rd_en |-> acc); // R5
  AST_READ_AT_OWN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    tpl_rd_en |-> slot && (c_e == CW'(tpl_rd_col))); // R5
  AST_READ_EVERY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    slot |-> tpl_rd_en); // R5
  AST_RESULT_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> out_valid); // R3
  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(done)); // R4
  AST_IDLE_BEFORE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !p_e |-> !out_valid && !tpl_rd_en); // R8

endmodule

bind corr_column_chain corr_column_chain_chk #(
  .ROWS(ROWS), .COLS(COLS), .SUM_W(SUM_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_tok     (in_tok),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sum    (out_sum),
  .tpl_rd_en  (tpl_rd_en),
  .tpl_rd_col (tpl_rd_col)
);

// File: tb/corr_column_chain_test.sv
`timescale 1ns/1ps
module corr_column_chain_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_pix = '0;
  logic        in_tok = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [12:0] out_sum;
  logic        tpl_rd_en;
  logic [3:0]  tpl_rd_col;
  logic [15:0] tpl_rd_bits;

  logic [15:0] tmem [16];
  logic [7:0]  img  [64][16];

  int checks = 0, errors = 0;
  int mchecks = 0, merrors = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;

  // Observation log, written only by the monitor.
  int          got_n = 0;
  logic [12:0] got_v [256];
  int          got_pos [256];
  int          acc = 0;
  int          rd_n = 0, rd_bad = 0, hold_n = 0;
  bit          hold_prev = 1'b0;
  logic [12:0] hold_sum = '0;

  always #5 clk = ~clk;

  corr_column_chain uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_tok(in_tok),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
    .tpl_rd_en(tpl_rd_en), .tpl_rd_col(tpl_rd_col), .tpl_rd_bits(tpl_rd_bits)
  );

  always_comb tpl_rd_bits = tmem[tpl_rd_col];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp_mode ? ((cyc % 3) == 2) : 1'b1;
    if (cyc > 150000) begin
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
      $finish;
    end
  end

  // Monitor: samples between edges.
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        mchecks++;
        if (!(out_valid && out_sum == hold_sum)) begin
          merrors++;
          $display("FAIL R7 held result actual %0d expected %0d", out_sum, hold_sum);
        end
      end
      if (out_valid && !out_ready) begin
        hold_n++;
        mchecks++;
        if (in_ready) begin
          merrors++;
          $display("FAIL R7 in_ready during hold actual %0d expected %0d", in_ready, 0);
        end
      end
      hold_prev = out_valid && !out_ready;
      hold_sum  = out_sum;
      if (out_valid && out_ready) begin
        got_v[got_n]   = out_sum;
        got_pos[got_n] = acc;
        got_n++;
      end
      if (in_valid && in_ready) acc = in_tok ? 1 : acc + 1;
      if (tpl_rd_en) begin
        rd_n++;
        if ((acc - 1) != 16 * int'(tpl_rd_col)) rd_bad++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] p, input bit t);
    in_valid = 1'b1; in_pix = p; in_tok = t;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_tok = 1'b0;
  endtask

  task automatic send_cols(input int n, input bit tok);
    for (int c = 0; c < n; c++)
      for (int r = 0; r < 16; r++)
        push(img[c][r], tok && c == 0 && r == 0);
  endtask

  task automatic fill_img(input int seed);
    for (int c = 0; c < 64; c++)
      for (int r = 0; r < 16; r++)
        img[c][r] = 8'((c * 37 + r * 11 + seed * 53) ^ (c * r));
  endtask

  task automatic fill_tmpl(input int seed);
    for (int j = 0; j < 16; j++)
      tmem[j] = (16'h1 << ((j * 5 + seed) % 16)) | (16'h1 << ((j * 3 + 7 + seed) % 16));
  endtask

  function automatic int expect_at(input int c);
    int s = 0;
    for (int j = 0; j < 16; j++)
      for (int r = 0; r < 16; r++)
        if (tmem[j][r]) s += img[c + j][r];
    return s % 8192;
  endfunction

  task automatic check_results(input int base, input int nexp, input string req, input bit pos_chk);
    chk(got_n - base == nexp, "R3 result count", got_n - base, nexp);
    for (int i = 0; i < nexp && i < got_n - base; i++) begin
      chk(int'(got_v[base + i]) == expect_at(i), req, got_v[base + i], expect_at(i));
      if (pos_chk)
        chk(got_pos[base + i] == 256 + 16 * i, "R4 result position", got_pos[base + i], 256 + 16 * i);
    end
  endtask

  task automatic t_reset_and_pretoken();
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    begin
      int g0 = got_n, r0 = rd_n;
      fill_img(9);
      for (int i = 0; i < 40; i++) push(img[i / 16][i % 16], 1'b0);
      idle(4);
      chk(got_n == g0, "R8 no result before token", got_n - g0, 0);
      chk(rd_n == r0, "R8 no read before token", rd_n - r0, 0);
    end
  endtask

  task automatic t_basic();
    int g0 = got_n, r0 = rd_n, b0 = rd_bad;
    fill_tmpl(1); fill_img(1);
    send_cols(20, 1'b1);
    idle(4);
    check_results(g0, 5, "R2 correlation", 1'b1);
    chk(rd_n - r0 == 16, "R5 read count", rd_n - r0, 16);
    chk(rd_bad == b0, "R5 read slots", rd_bad - b0, 0);
  endtask

  task automatic t_row_order();
    int g0 = got_n;
    for (int j = 0; j < 16; j++) tmem[j] = '0;
    tmem[0]  = 16'h0001;
    tmem[15] = 16'h8000;
    fill_img(4);
    send_cols(17, 1'b1);
    idle(4);
    chk(got_n - g0 == 2, "R6 result count", got_n - g0, 2);
    for (int i = 0; i < 2 && i < got_n - g0; i++) begin
      int e = (img[i][0] + img[i + 15][15]) % 8192;
      chk(int'(got_v[g0 + i]) == e, "R6 bit and column order", got_v[g0 + i], e);
    end
  endtask

  task automatic t_wrap();
    int g0 = got_n;
    for (int j = 0; j < 16; j++) tmem[j] = 16'hFFFF;
    for (int c = 0; c < 64; c++)
      for (int r = 0; r < 16; r++) img[c][r] = 8'hFF;
    send_cols(17, 1'b1);
    idle(4);
    chk(got_n - g0 == 2, "R10 result count", got_n - g0, 2);
    for (int i = 0; i < 2 && i < got_n - g0; i++)
      chk(got_v[g0 + i] == 13'd7936, "R10 wrap", got_v[g0 + i], 7936);
  endtask

  task automatic t_retoken();
    int g0 = got_n, g1;
    fill_tmpl(3); fill_img(2);
    send_cols(18, 1'b1);
    idle(3);
    check_results(g0, 3, "R9 first frame", 1'b1);
    for (int r = 0; r < 5; r++) push(img[18][r], 1'b0);
    g1 = got_n;
    fill_tmpl(6); fill_img(7);
    send_cols(17, 1'b1);
    idle(4);
    check_results(g1, 2, "R9 mid-column token", 1'b1);
  endtask

  task automatic t_backpressure();
    int g0 = got_n, h0 = hold_n;
    fill_tmpl(5); fill_img(3);
    bp_mode = 1'b1;
    send_cols(18, 1'b1);
    idle(12);
    bp_mode = 1'b0;
    idle(3);
    check_results(g0, 3, "R7 values under stall", 1'b0);
    chk(hold_n > h0, "R7 stall exercised", hold_n - h0, 1);
  endtask

  initial begin
    for (int j = 0; j < 16; j++) tmem[j] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset_and_pretoken();
    t_basic();
    t_row_order();
    t_wrap();
    t_retoken();
    t_backpressure();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end

endmodule